// File: doc/BRIEF.md
# Power-Management Interrupt Event Router

This block gathers single-cycle event pulses from several power-management and trap sources into sticky status flags. Each flag is qualified by its own enable, and the qualified flags are combined and steered to one of two outputs: an active-low system management interrupt (`smi_n`) or an active-high system control interrupt (`sci`). One select bit in the control register chooses the output. SMI generation also needs a global SMI enable.

SMI is one-shot. After `smi_n` goes low, the end-of-SMI flag clears itself and the line stays low until software writes that flag again. If qualified status is still pending at that point, the line rises for exactly one cycle and then falls again.

The sources are:
- a battery-low pin;
- a set of device address-trap monitors;
- three SMBus sources (slave message, alert pin, host notify);
- an embedded-controller port access;
- a sleep-enable write.

A small register port gives software access to the control bits, the enables and the write-one-to-clear status. The same port sets a static interrupt-line code that selects which interrupt number the SCI is routed to.

Top module: `pm_event_router`

## Requirements
- R1: After reset the outputs and registers are as follows. `smi_n`=1, `sci`=0 and `sci_line`=9. Every enable, status, select, global-enable and mode bit is 0, the end-of-SMI flag reads 1, and `rdata`=0.
- R2: SCI sources and timing. Only the SMBus status and the embedded-controller status can cause an SCI. `sci` is high in the cycle after a cycle in which the select bit is 1 and at least one of those two flags is set together with its enable. Otherwise `sci` is low.
- R3: SMI conditions. `smi_n` can fall only after a cycle in which the select bit is 0, the global SMI enable is 1, and at least one status flag is set together with its enable.
- R4: Status flag behaviour.
  - Every status flag is set by its event pulse, whatever the enables are.
  - A flag stays set until software writes 1 to its bit in the status register. Writing 0 has no effect.
  - When an event pulse and a clear arrive in the same cycle, the flag ends up set.
- R5: SMI-only causes. Battery-low, sleep-write trap and each device trap n have their own enable. They can raise only SMI and never drive `sci`.
- R6: SMI assertion and hold.
  - When SMI is armed and its condition holds, `smi_n` falls one cycle later and the end-of-SMI flag reads 0.
  - `smi_n` then stays low until a write of 1 to the end-of-SMI bit.
  - That write raises `smi_n` and re-arms SMI.
- R7: Re-assertion pulse. When end-of-SMI is written while qualified SMI status is still pending, `smi_n` is high for exactly one cycle and then low again.
- R8: Shared SMBus flag.
  - The SMBus slave pulse, the SMBus alert pulse and the host-notify pulse all set the one SMBus status flag.
  - The host-notify pulse sets it only when the notify enable is 1.
  - A host-notify pulse with that enable at 0 leaves the flag clear.
- R9: Embedded-controller cause. An embedded-controller port access sets its own status flag. That flag raises SMI or SCI only when its enable is 1.
- R10: Interrupt-line code.
  - The 3-bit code in CTRL[6:4] maps codes 0, 1 and 2 to lines 9, 10 and 11, and codes 3 to 6 to lines 20 to 23.
  - A code from 3 to 6 is accepted only when the same write sets the mode bit CTRL[3]. Code 7, or a code from 3 to 6 written with the mode bit at 0, leaves the stored code unchanged.
  - If the stored code is 3 or above and a write clears the mode bit without supplying an acceptable code, the stored code becomes 0.
  - `sci_line` shows the line number of the stored code one cycle after the code changes.
- R11: Register map and read timing.
  - CTRL (address 0) has these fields:

    | Bit(s) | Field |
    |---|---|
    | 0 | select (1 = SCI) |
    | 1 | global SMI enable |
    | 2 | end-of-SMI |
    | 3 | mode bit |
    | 6:4 | line code |

  - EN (address 1) has these fields:

    | Bit(s) | Field |
    |---|---|
    | 0 | battery-low |
    | 1 | sleep trap |
    | 2 | SMBus |
    | 3 | host notify |
    | 4 | embedded controller |
    | 8+n | device trap n |

  - STS (address 2) has these fields:

    | Bit(s) | Field |
    |---|---|
    | 0 | battery-low |
    | 1 | sleep trap |
    | 2 | SMBus |
    | 3 | embedded controller |
    | 8+n | device trap n |

  - Address 3 reads 0 and ignores writes.
  - `rdata` presents, one cycle after a cycle with a given `addr`, the value that register held during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Registered read data |
| batlow_evt | input | 1 | Battery-low event pulse |
| slp_wr_evt | input | 1 | Sleep-enable written with 1 |
| trap_evt | input | NUM_TRAPS | Device address-trap hit pulses |
| smb_slave_evt | input | 1 | SMBus slave message pulse |
| smb_alert_evt | input | 1 | SMBus alert pulse |
| smb_notify_evt | input | 1 | SMBus host-notify pulse |
| ec_port_evt | input | 1 | Embedded-controller port access pulse |
| smi_n | output | 1 | System management interrupt, active low |
| sci | output | 1 | System control interrupt, active high |
| sci_line | output | 5 | Interrupt number the SCI is routed to |

## Verification
The bench targets the following corner cases:
- An event pulse and a write-one-to-clear of the same flag in the same cycle. A design that lets the clear win loses the event.
- An end-of-SMI write while status is still pending. A design without the one-cycle high pulse either leaves SMI stuck low or never asserts it again.
- A host-notify pulse with its enable off. This must leave the shared SMBus flag clear.
- SMI-only causes with the select bit at 1. These must never drive `sci`.
- Line codes 20 to 23 requested without the mode bit, and the mode bit later cleared. A design with wrong code acceptance routes the SCI to a line that is not allowed.

Long constrained-random runs compare every output against a bench model cycle by cycle.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  localparam int REG_CTRL = 0;
  localparam int REG_EN   = 1;
  localparam int REG_STS  = 2;

  localparam int CTL_SEL  = 0;
  localparam int CTL_GSMI = 1;
  localparam int CTL_EOS  = 2;
  localparam int CTL_APIC = 3;
  localparam int CTL_CODE = 4;

  localparam int EN_BAT    = 0;
  localparam int EN_SLP    = 1;
  localparam int EN_SMB    = 2;
  localparam int EN_NOTIFY = 3;
  localparam int EN_EC     = 4;

  localparam int ST_BAT = 0;
  localparam int ST_SLP = 1;
  localparam int ST_SMB = 2;
  localparam int ST_EC  = 3;

  localparam int TRAP_LSB = 8;

  // accept a new line code only if it is legal under the new mode bit
  function automatic logic [2:0] next_line_code(input logic [2:0] old_code,
                                                input logic [2:0] new_code,
                                                input logic       mode);
    if (new_code <= 3'd2 || (mode && new_code <= 3'd6))
      return new_code;
    else if (old_code <= 3'd2 || mode)
      return old_code;
    else
      return 3'd0;
  endfunction

  function automatic logic [4:0] line_number(input logic [2:0] code);
    case (code)
      3'd0: return 5'd9;
      3'd1: return 5'd10;
      3'd2: return 5'd11;
      3'd3: return 5'd20;
      3'd4: return 5'd21;
      3'd5: return 5'd22;
      3'd6: return 5'd23;
      default: return 5'd9;
    endcase
  endfunction
endpackage

// File: rtl/pmr_regs.sv
module pmr_regs
  import pmr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 2,
  parameter int NUM_TRAPS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic                 sci_sel,
  output logic                 gsmi_en,
  output logic                 apic_mode,
  output logic [2:0]           line_code,
  output logic [4:0]           sci_line,
  output logic [4:0]           cause_en,
  output logic [NUM_TRAPS-1:0] trap_en,
  output logic                 eos_wr,
  output logic                 sts_wr
);
  logic ctrl_wr, en_wr;

  assign ctrl_wr = wr_en && (addr == ADDR_W'(REG_CTRL));
  assign en_wr   = wr_en && (addr == ADDR_W'(REG_EN));
  assign sts_wr  = wr_en && (addr == ADDR_W'(REG_STS));
  assign eos_wr  = ctrl_wr && wdata[CTL_EOS];

  always_ff @(posedge clk) begin
    if (rst) begin
      sci_sel   <= 1'b0;
      gsmi_en   <= 1'b0;
      apic_mode <= 1'b0;
      line_code <= 3'd0;
      sci_line  <= 5'd9;
      cause_en  <= '0;
      trap_en   <= '0;
    end else begin
      sci_line <= line_number(line_code);
      if (ctrl_wr) begin
        sci_sel   <= wdata[CTL_SEL];
        gsmi_en   <= wdata[CTL_GSMI];
        apic_mode <= wdata[CTL_APIC];
        line_code <= next_line_code(line_code, wdata[CTL_CODE +: 3],
                                    wdata[CTL_APIC]);
      end
      if (en_wr) begin
        cause_en <= wdata[4:0];
        trap_en  <= wdata[TRAP_LSB +: NUM_TRAPS];
      end
    end
  end

  // R10: high line codes never stand without the mode bit
  assert_line_legal_R10: assert property (@(posedge clk) disable iff (rst)
    (line_code > 3'd2) |-> apic_mode);
  assert_line_valid_R10: assert property (@(posedge clk) disable iff (rst)
    line_code != 3'd7);
endmodule

// File: rtl/pmr_status.sv
module pmr_status
  import pmr_pkg::*;
#(
  parameter int NUM_TRAPS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 batlow_evt,
  input  logic                 slp_wr_evt,
  input  logic [NUM_TRAPS-1:0] trap_evt,
  input  logic                 smb_slave_evt,
  input  logic                 smb_alert_evt,
  input  logic                 smb_notify_evt,
  input  logic                 ec_port_evt,
  input  logic                 notify_en,
  input  logic                 sts_wr,
  input  logic [3:0]           clr_main,
  input  logic [NUM_TRAPS-1:0] clr_trap,
  output logic [3:0]           sts_main,
  output logic [NUM_TRAPS-1:0] trap_sts
);
  logic [3:0] set_main;

  assign set_main[ST_BAT] = batlow_evt;
  assign set_main[ST_SLP] = slp_wr_evt;
  assign set_main[ST_SMB] = smb_slave_evt | smb_alert_evt |
                            (smb_notify_evt & notify_en);
  assign set_main[ST_EC]  = ec_port_evt;

  for (genvar i = 0; i < 4; i++) begin : g_main
    always_ff @(posedge clk) begin
      if (rst) sts_main[i] <= 1'b0;
      else     sts_main[i] <= set_main[i] |
                              (sts_main[i] & ~(sts_wr & clr_main[i]));
    end
    // R4: a set flag survives unless cleared
    assert_main_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      (sts_main[i] && !(sts_wr && clr_main[i])) |=> sts_main[i]);
  end

  for (genvar t = 0; t < NUM_TRAPS; t++) begin : g_trap
    always_ff @(posedge clk) begin
      if (rst) trap_sts[t] <= 1'b0;
      else     trap_sts[t] <= trap_evt[t] |
                              (trap_sts[t] & ~(sts_wr & clr_trap[t]));
    end
    // R4: an event pulse beats a same-cycle clear
    assert_trap_event_wins_R4: assert property (@(posedge clk) disable iff (rst)
      trap_evt[t] |=> trap_sts[t]);
  end

  assert_batlow_set_R4: assert property (@(posedge clk) disable iff (rst)
    batlow_evt |=> sts_main[ST_BAT]);
endmodule

// File: rtl/pmr_smi_ctl.sv
module pmr_smi_ctl (
  input  logic clk,
  input  logic rst,
  input  logic smi_req,
  input  logic sci_req,
  input  logic eos_wr,
  output logic smi_n,
  output logic sci,
  output logic eos
);
  always_ff @(posedge clk) begin
    if (rst) begin
      smi_n <= 1'b1;
      sci   <= 1'b0;
      eos   <= 1'b1;
    end else begin
      sci <= sci_req;
      if (smi_n && eos && smi_req) begin
        smi_n <= 1'b0;
        eos   <= 1'b0;
      end else if (eos_wr) begin
        smi_n <= 1'b1;
        eos   <= 1'b1;
      end
    end
  end

  // R6: assertion consumes the end-of-SMI flag
  assert_eos_consumed_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(smi_n) |-> !eos);
  // R6: SMI# holds low until end-of-SMI is written
  assert_smi_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!smi_n && !eos_wr) |=> !smi_n);
  assert_smi_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(smi_n) |-> $past(smi_req));
endmodule

// File: rtl/pm_event_router.sv
module pm_event_router
  import pmr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 2,
  parameter int NUM_TRAPS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic                 batlow_evt,
  input  logic                 slp_wr_evt,
  input  logic [NUM_TRAPS-1:0] trap_evt,
  input  logic                 smb_slave_evt,
  input  logic                 smb_alert_evt,
  input  logic                 smb_notify_evt,
  input  logic                 ec_port_evt,
  output logic                 smi_n,
  output logic                 sci,
  output logic [4:0]           sci_line
);
  localparam int TRAP_MSB = TRAP_LSB + NUM_TRAPS - 1;

  logic                 sci_sel, gsmi_en, apic_mode, eos, eos_wr, sts_wr;
  logic [2:0]           line_code;
  logic [4:0]           cause_en;
  logic [NUM_TRAPS-1:0] trap_en, trap_sts;
  logic [3:0]           sts_main;
  logic                 shared_pend, smi_only_pend, smi_req, sci_req;
  logic [DATA_W-1:0]    rd_next;

  pmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_TRAPS(NUM_TRAPS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sci_sel(sci_sel), .gsmi_en(gsmi_en), .apic_mode(apic_mode),
    .line_code(line_code), .sci_line(sci_line), .cause_en(cause_en),
    .trap_en(trap_en), .eos_wr(eos_wr), .sts_wr(sts_wr)
  );

  pmr_status #(.NUM_TRAPS(NUM_TRAPS)) u_status (
    .clk(clk), .rst(rst), .batlow_evt(batlow_evt), .slp_wr_evt(slp_wr_evt),
    .trap_evt(trap_evt), .smb_slave_evt(smb_slave_evt),
    .smb_alert_evt(smb_alert_evt), .smb_notify_evt(smb_notify_evt),
    .ec_port_evt(ec_port_evt), .notify_en(cause_en[EN_NOTIFY]),
    .sts_wr(sts_wr), .clr_main(wdata[3:0]),
    .clr_trap(wdata[TRAP_MSB:TRAP_LSB]),
    .sts_main(sts_main), .trap_sts(trap_sts)
  );

  assign shared_pend   = (sts_main[ST_SMB] & cause_en[EN_SMB]) |
                         (sts_main[ST_EC]  & cause_en[EN_EC]);
  assign smi_only_pend = (sts_main[ST_BAT] & cause_en[EN_BAT]) |
                         (sts_main[ST_SLP] & cause_en[EN_SLP]) |
                         (|(trap_sts & trap_en));
  assign smi_req = !sci_sel && gsmi_en && (shared_pend || smi_only_pend);
  assign sci_req = sci_sel && shared_pend;

  pmr_smi_ctl u_smi (
    .clk(clk), .rst(rst), .smi_req(smi_req), .sci_req(sci_req),
    .eos_wr(eos_wr), .smi_n(smi_n), .sci(sci), .eos(eos)
  );

  always_comb begin
    rd_next = '0;
    case (addr)
      ADDR_W'(REG_CTRL): begin
        rd_next[CTL_SEL]       = sci_sel;
        rd_next[CTL_GSMI]      = gsmi_en;
        rd_next[CTL_EOS]       = eos;
        rd_next[CTL_APIC]      = apic_mode;
        rd_next[CTL_CODE +: 3] = line_code;
      end
      ADDR_W'(REG_EN): begin
        rd_next[4:0]                  = cause_en;
        rd_next[TRAP_MSB:TRAP_LSB]    = trap_en;
      end
      ADDR_W'(REG_STS): begin
        rd_next[3:0]                  = sts_main;
        rd_next[TRAP_MSB:TRAP_LSB]    = trap_sts;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R3: SMI only fires with select 0 and global enable 1
  assert_smi_gated_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(smi_n) |-> $past(gsmi_en && !sci_sel));
  // R2: SCI only with select 1
  assert_sci_sel_R2: assert property (@(posedge clk) disable iff (rst)
    sci |-> $past(sci_sel));
  // R5: SMI-only causes alone never produce SCI
  assert_sci_shared_only_R5: assert property (@(posedge clk) disable iff (rst)
    !shared_pend |=> !sci);
  // R2/R3: the two interrupt outputs never run together
  assert_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    (sci && $fell(smi_n)) == 1'b0);
endmodule

// File: tb/pm_event_router_tb.sv
module pm_event_router_tb;
  localparam int DW = 16;
  localparam int AW = 2;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic batlow_evt = 0, slp_wr_evt = 0, smb_slave_evt = 0, smb_alert_evt = 0;
  logic smb_notify_evt = 0, ec_port_evt = 0;
  logic [NT-1:0] trap_evt = '0;
  logic smi_n, sci;
  logic [4:0] sci_line;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pm_event_router #(.DATA_W(DW), .ADDR_W(AW), .NUM_TRAPS(NT)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .batlow_evt(batlow_evt), .slp_wr_evt(slp_wr_evt),
    .trap_evt(trap_evt), .smb_slave_evt(smb_slave_evt),
    .smb_alert_evt(smb_alert_evt), .smb_notify_evt(smb_notify_evt),
    .ec_port_evt(ec_port_evt), .smi_n(smi_n), .sci(sci), .sci_line(sci_line)
  );

  // bench model state
  logic m_sel, m_gsmi, m_apic, m_eos, m_smin, m_sci;
  logic [2:0] m_code;
  logic [4:0] m_en, m_line;
  logic [NT-1:0] m_ten, m_tsts;
  logic [3:0] m_sts;
  logic [DW-1:0] m_rd;

  function automatic logic [2:0] f_code(logic [2:0] o, logic [2:0] n, logic md);
    if (n <= 2 || (md && n <= 6)) return n;
    if (o <= 2 || md) return o;
    return 3'd0;
  endfunction

  function automatic logic [4:0] f_line(logic [2:0] c);
    if (c <= 2) return 5'd9 + 5'(c);
    return 5'd17 + 5'(c);
  endfunction

  function automatic logic [DW-1:0] f_read(logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    if (a == 0) v = {9'd0, m_code, m_apic, m_eos, m_gsmi, m_sel};
    else if (a == 1) begin v[4:0] = m_en; v[8 +: NT] = m_ten; end
    else if (a == 2) begin v[3:0] = m_sts; v[8 +: NT] = m_tsts; end
    return v;
  endfunction

  task automatic model_reset();
    m_sel = 0; m_gsmi = 0; m_apic = 0; m_eos = 1; m_smin = 1; m_sci = 0;
    m_code = 0; m_en = 0; m_line = 9; m_ten = 0; m_tsts = 0; m_sts = 0; m_rd = 0;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R6 smi_n", 32'(smi_n), 32'(m_smin));
    chk("R2 sci", 32'(sci), 32'(m_sci));
    chk("R10 sci_line", 32'(sci_line), 32'(m_line));
    chk("R11 rdata", 32'(rdata), 32'(m_rd));
  endtask

  // one clock: compute next model from driven inputs, advance, compare
  task automatic tick();
    logic ctrl_w, en_w, sts_w, eos_w, pend_all, shared, req;
    logic [3:0] setm;
    logic [DW-1:0] nrd;
    ctrl_w = wr_en && addr == 0;
    en_w   = wr_en && addr == 1;
    sts_w  = wr_en && addr == 2;
    eos_w  = ctrl_w && wdata[2];
    shared = (m_sts[2] & m_en[2]) | (m_sts[3] & m_en[4]);
    pend_all = shared | (m_sts[0] & m_en[0]) | (m_sts[1] & m_en[1]) |
               (|(m_tsts & m_ten));
    req = !m_sel && m_gsmi && pend_all;
    nrd = f_read(addr);
    setm = {ec_port_evt, smb_slave_evt | smb_alert_evt | (smb_notify_evt & m_en[3]),
            slp_wr_evt, batlow_evt};
    @(posedge clk);
    m_rd = nrd;
    m_line = f_line(m_code);
    m_sci = m_sel && shared;
    if (m_smin && m_eos && req) begin m_smin = 0; m_eos = 0; end
    else if (eos_w) begin m_smin = 1; m_eos = 1; end
    m_sts  = setm | (m_sts & ~(sts_w ? wdata[3:0] : 4'd0));
    m_tsts = trap_evt | (m_tsts & ~(sts_w ? wdata[8 +: NT] : '0));
    if (ctrl_w) begin
      m_sel = wdata[0]; m_gsmi = wdata[1]; m_apic = wdata[3];
      m_code = f_code(m_code, wdata[6:4], wdata[3]);
    end
    if (en_w) begin m_en = wdata[4:0]; m_ten = wdata[8 +: NT]; end
    @(negedge clk);
    compare_all();
    wr_en = 0; addr = '0; wdata = '0; batlow_evt = 0; slp_wr_evt = 0;
    trap_evt = '0; smb_slave_evt = 0; smb_alert_evt = 0; smb_notify_evt = 0;
    ec_port_evt = 0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    wr_en = 1; addr = a; wdata = d; tick();
  endtask

  task automatic rd(logic [AW-1:0] a);
    addr = a; tick();
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 smi_n", 32'(smi_n), 1); chk("R1 sci", 32'(sci), 0);
    chk("R1 sci_line", 32'(sci_line), 9); chk("R1 rdata", 32'(rdata), 0);
    rd(0); rd(0); chk("R1 ctrl eos=1", 32'(rdata), 32'h4);

    // R4: status sets without enables, event beats clear
    batlow_evt = 1; tick();
    rd(2); rd(2); chk("R4 sticky batlow", 32'(rdata), 32'h1);
    wr_en = 1; addr = 2; wdata = 16'h0001; batlow_evt = 1; tick();
    rd(2); chk("R4 event beats clear", 32'(rdata), 32'h1);
    wr(2, 16'h0000); rd(2); rd(2); chk("R4 write 0 no effect", 32'(rdata), 32'h1);
    wr(2, 16'h0001); rd(2); rd(2); chk("R4 w1c clears", 32'(rdata), 32'h0);

    // R8: notify without enable is dropped, with enable sets SMB flag
    smb_notify_evt = 1; tick(); rd(2); rd(2);
    chk("R8 notify gated", 32'(rdata), 32'h0);
    wr(1, 16'h0008); smb_notify_evt = 1; tick(); rd(2); rd(2);
    chk("R8 notify sets smb", 32'(rdata), 32'h4);
    wr(2, 16'h0004); smb_alert_evt = 1; tick(); rd(2); rd(2);
    chk("R8 alert sets smb", 32'(rdata), 32'h4);
    wr(2, 16'h0004);

    // R5: battery-low with select=1 gives no SCI and no SMI
    wr(1, 16'h0001); wr(0, 16'h0007); batlow_evt = 1; tick(); tick(); tick();
    chk("R5 batlow no sci", 32'(sci), 0); chk("R5 batlow no smi", 32'(smi_n), 1);
    // R3/R6: select=0 with global enable -> SMI falls, eos reads 0
    wr(0, 16'h0002); tick();
    chk("R6 smi asserted", 32'(smi_n), 0);
    rd(0); rd(0); chk("R6 eos cleared", 32'(rdata), 32'h2);
    // R7: eos write with status still pending -> one high cycle
    wr(0, 16'h0006); chk("R7 pulse high", 32'(smi_n), 1);
    tick(); chk("R7 low again", 32'(smi_n), 0);
    wr(2, 16'h0001); wr(0, 16'h0006); tick();
    chk("R6 rearmed idle", 32'(smi_n), 1);

    // R9: EC with enable, SCI routing
    wr(1, 16'h0010); wr(0, 16'h0001); ec_port_evt = 1; tick(); tick();
    chk("R9 ec sci", 32'(sci), 1);
    wr(2, 16'h0008); tick(); chk("R2 sci drops", 32'(sci), 0);

    // R10 line codes
    wr(0, 16'h0040); tick(); tick(); chk("R10 code4 no mode", 32'(sci_line), 9);
    wr(0, 16'h0068); tick(); chk("R10 code6 mode", 32'(sci_line), 23);
    wr(0, 16'h0078); tick(); chk("R10 code7 kept", 32'(sci_line), 23);
    wr(0, 16'h0030); tick(); tick(); chk("R10 mode cleared", 32'(sci_line), 9);
    wr(0, 16'h0020); tick(); chk("R10 code2", 32'(sci_line), 11);
    // R11 unused address
    wr(3, 16'hFFFF); rd(3); rd(3); chk("R11 addr3 zero", 32'(rdata), 0);

    // constrained random against the model
    for (int i = 0; i < 20000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 25) begin
        wr_en = 1; addr = AW'($urandom_range(0, 3));
        wdata = DW'($urandom);
        if (addr == 2 && $urandom_range(0, 1) == 1) wdata = '1;
      end else addr = AW'($urandom_range(0, 3));
      batlow_evt     = ($urandom_range(0, 15) == 0);
      slp_wr_evt     = ($urandom_range(0, 15) == 0);
      trap_evt       = NT'($urandom) & NT'($urandom) & NT'($urandom);
      smb_slave_evt  = ($urandom_range(0, 15) == 0);
      smb_alert_evt  = ($urandom_range(0, 15) == 0);
      smb_notify_evt = ($urandom_range(0, 7) == 0);
      ec_port_evt    = ($urandom_range(0, 15) == 0);
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule